// File: doc/BRIEF.md
# Two-Level Three-State Bus Byte Memory

This block is a 32-entry byte store organised as four banks of eight byte-wide lines. Each line has a three-state driver onto its bank's shared read net. Each bank has a second three-state driver onto the shared net at the top of the block. No multiplexer sits anywhere on the read path. Read data is merged because only one driver on each net is ever enabled.

A 5-bit address is split into two fields. The upper field is decoded into one-hot bank selects. Inside the selected bank, the lower field picks one line. Writes are synchronous to the rising clock edge. Reads are combinational from the stored value while read enable is high. While read enable is low, the output net is left undriven.

Top module: `busmem32`

## Requirements
- R1: The address splits into two fields. Bits [4:3] choose the bank and bits [2:0] choose the line inside that bank, with lines counted from zero. For example, 5'b00111 is bank 0, line 7, and 5'd30 is bank 3, line 6.
- R2: The bank decoder produces exactly one active bank select out of four, taken from address bits [4:3].
- R3: On a rising clock edge with `wr_en` high and `rst` low, the addressed line takes the value of `wr_data`.
- R4: A write changes no line other than the addressed one. When `wr_en` is low, no line changes.
- R5: On a rising clock edge with `rst` high, every line in every bank is cleared to zero. Reset takes priority over a write in the same cycle.
- R6: While `rd_en` is high, `rd_data` shows the stored contents of the addressed line in the same cycle, with no clock edge in between.
- R7: At most one line drives a bank's internal read net. At most one bank drives the top-level read net.
- R8: The following sequence returns the values shown:
  - reset
  - write 25 to address 30
  - write 15 to address 20
  - read address 12, which returns 0
  - write 18 to address 10
  - read address 15, which returns 0
  - read address 30, which returns 25
  - read address 10, which returns 18
- R9: A read and a write to the same address in the same cycle returns the value held before that edge. After the edge, the read returns the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes and reset act on its rising edge |
| rst | input | 1 | Synchronous active-high clear of all lines |
| addr | input | 5 | Bank field [4:3], line field [2:0] |
| wr_en | input | 1 | Store `wr_data` into the addressed line at the next edge |
| rd_en | input | 1 | Enable the three-state read path |
| wr_data | input | 8 | Byte to store |
| rd_data | output | 8 | Addressed line while `rd_en` is high; undriven otherwise |

## Verification
The bench keeps a behavioural 32-entry array and compares every read against it. It targets the following corner cases:

- **Field boundaries.** Addresses 7/8, 15/16 and 23/24 are exercised. A design that swapped or mis-sliced the bank and line fields would return another bank's byte.
- **Writes beside a line.** Neighbouring lines are read back after each write. A decoder that enabled more than one line would corrupt them.
- **Reset with a write pending.** Reset is applied while a write is requested. A design that gave the write priority would leave a nonzero byte behind.
- **Read during a write.** A read is made in the same cycle as a write to that address. A design with a write-through path would show the new byte one cycle early.

// File: rtl/busmem_pkg.sv
package busmem_pkg;
  localparam int unsigned DATA_W_DEF = 8;
  localparam int unsigned LINE_AW_DEF = 3;
  localparam int unsigned BANK_AW_DEF = 2;
endpackage

// File: rtl/busmem_tribuf.sv
module busmem_tribuf #(
  parameter int unsigned W = 8
) (
  input  logic         en,
  input  logic [W-1:0] d,
  output wire  [W-1:0] q
);
  assign q = en ? d : {W{1'bz}};
endmodule

// File: rtl/busmem_line.sv
module busmem_line #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] wr_data,
  output wire  [DATA_W-1:0] bus_q
);
  logic [DATA_W-1:0] store_q;

  always_ff @(posedge clk) begin
    if (rst)               store_q <= '0;
    else if (sel && wr_en) store_q <= wr_data;
  end

  busmem_tribuf #(.W(DATA_W)) i_drv (
    .en (sel && rd_en),
    .d  (store_q),
    .q  (bus_q)
  );

  // R3: a selected write lands on the next edge
  p_write_lands_r3: assert property (@(posedge clk) disable iff (rst)
    (sel && wr_en) |=> (store_q == $past(wr_data)));

  // R4: an unselected line holds its value
  p_hold_unsel_r4: assert property (@(posedge clk) disable iff (rst)
    !(sel && wr_en) |=> $stable(store_q));

  // R5: reset clears the line
  p_clear_r5: assert property (@(posedge clk)
    rst |=> (store_q == '0));
endmodule

// File: rtl/busmem_bank.sv
module busmem_bank #(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned LINE_AW = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cs,
  input  logic [LINE_AW-1:0] line_addr,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [DATA_W-1:0]  wr_data,
  output wire  [DATA_W-1:0]  bank_q
);
  localparam int unsigned LINES = 1 << LINE_AW;

  logic [LINES-1:0]  line_sel;
  logic [LINES-1:0]  line_drv;
  wire  [DATA_W-1:0] local_bus;

  for (genvar i = 0; i < LINES; i++) begin : g_line
    assign line_sel[i] = cs && (line_addr == LINE_AW'(i));
    assign line_drv[i] = line_sel[i] && rd_en;

    busmem_line #(.DATA_W(DATA_W)) i_line (
      .clk     (clk),
      .rst     (rst),
      .sel     (line_sel[i]),
      .wr_en   (wr_en),
      .rd_en   (rd_en),
      .wr_data (wr_data),
      .bus_q   (local_bus)
    );
  end

  busmem_tribuf #(.W(DATA_W)) i_bank_drv (
    .en (cs && rd_en),
    .d  (local_bus),
    .q  (bank_q)
  );

  // R7: never two drivers on the bank net
  p_one_line_drv_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(line_drv));

  // R1: a selected bank enables exactly the line named by the line field
  p_line_field_r1: assert property (@(posedge clk) disable iff (rst)
    cs |-> ($countones(line_sel) == 1 && line_sel[line_addr]));
endmodule

// File: rtl/busmem32.sv
module busmem32 (
  input  logic       clk,
  input  logic       rst,
  input  logic [4:0] addr,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [7:0] wr_data,
  output wire  [7:0] rd_data
);
  import busmem_pkg::*;

  localparam int unsigned DATA_W  = DATA_W_DEF;
  localparam int unsigned LINE_AW = LINE_AW_DEF;
  localparam int unsigned BANK_AW = BANK_AW_DEF;
  localparam int unsigned BANKS   = 1 << BANK_AW;

  logic [BANKS-1:0]   bank_cs;
  logic [BANK_AW-1:0] bank_field;
  logic [LINE_AW-1:0] line_field;

  assign bank_field = addr[LINE_AW +: BANK_AW];
  assign line_field = addr[LINE_AW-1:0];

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    assign bank_cs[b] = (bank_field == BANK_AW'(b));

    busmem_bank #(.DATA_W(DATA_W), .LINE_AW(LINE_AW)) i_bank (
      .clk       (clk),
      .rst       (rst),
      .cs        (bank_cs[b]),
      .line_addr (line_field),
      .wr_en     (wr_en),
      .rd_en     (rd_en),
      .wr_data   (wr_data),
      .bank_q    (rd_data)
    );
  end

  // R2: exactly one bank select at all times
  p_bank_onehot_r2: assert property (@(posedge clk) disable iff (rst)
    $countones(bank_cs) == 1);

  // R1: the active select matches the upper address field
  p_bank_field_r1: assert property (@(posedge clk) disable iff (rst)
    bank_cs[addr[4:3]]);
endmodule

// File: tb/test_busmem32.sv
`timescale 1ns/1ps
module test_busmem32;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] addr = '0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [7:0] wr_data = '0;
  wire  [7:0] rd_data;

  int vectors = 0;
  int misses  = 0;
  int model [32];
  bit done = 1'b0;

  always #4 clk = ~clk;

  busmem32 i_busmem32 (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en),
    .rd_en(rd_en), .wr_data(wr_data), .rd_data(rd_data)
  );

  // One cycle: drive at the falling edge, compare the read, then step the model at the rising edge.
  task automatic cyc(input bit r, input bit we, input bit re,
                     input int a, input int d, input string tag,
                     input int exp_override = -1);
    int expv;
    @(negedge clk);
    rst = r; wr_en = we; rd_en = re; addr = 5'(a); wr_data = 8'(d);
    #1;
    if (re) begin
      expv = (exp_override >= 0) ? exp_override : model[a];
      vectors++;
      if (rd_data !== 8'(expv)) begin
        misses++;
        $display("FAIL %s addr=%0d actual=%0d expected=%0d", tag, a, rd_data, expv);
      end
    end
    @(posedge clk);
    if (r) begin
      for (int i = 0; i < 32; i++) model[i] = 0;
    end else if (we) begin
      model[a] = d & 8'hff;
    end
  endtask

  initial begin
    #150000;
    if (!done) begin
      misses++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) model[i] = 0;

    // R5: reset with a write pending, then check every line reads zero
    cyc(1, 1, 0, 5, 8'h77, "R5");
    cyc(1, 0, 0, 0, 0, "R5");
    for (int a = 0; a < 32; a++) cyc(0, 0, 1, a, 0, "R5_reset_state");

    // R8: the fixed sequence with its known answers
    cyc(1, 0, 0, 0, 0, "R8");
    cyc(0, 1, 0, 30, 25, "R8");
    cyc(0, 1, 0, 20, 15, "R8");
    cyc(0, 0, 1, 12, 0, "R8", 0);
    cyc(0, 1, 0, 10, 18, "R8");
    cyc(0, 0, 1, 15, 0, "R8", 0);
    cyc(0, 0, 1, 30, 0, "R8", 25);
    cyc(0, 0, 1, 10, 0, "R8", 18);

    // R1: the field boundaries, with 5'b00111 as bank 0 line 7
    cyc(0, 1, 0, 7, 8'hA7, "R1");
    cyc(0, 1, 0, 8, 8'hB8, "R1");
    cyc(0, 1, 0, 23, 8'hC3, "R1");
    cyc(0, 1, 0, 24, 8'hD4, "R1");
    cyc(0, 0, 1, 7, 0, "R1", 8'hA7);
    cyc(0, 0, 1, 8, 0, "R1", 8'hB8);
    cyc(0, 0, 1, 23, 0, "R1");
    cyc(0, 0, 1, 24, 0, "R1");

    // R3 R4: every line gets a distinct byte, then all are read back
    for (int a = 0; a < 32; a++) cyc(0, 1, 0, a, (a * 37 + 11) & 255, "R3");
    for (int a = 0; a < 32; a++) cyc(0, 0, 1, a, 0, "R4");

    // R4: with wr_en low nothing changes
    for (int a = 0; a < 32; a++) cyc(0, 0, 0, a, 8'hEE, "R4");
    for (int a = 0; a < 32; a++) cyc(0, 0, 1, a, 0, "R4_no_write");

    // R9: read during a write shows the old byte, the next read shows the new one
    cyc(0, 1, 1, 17, 8'h5A, "R9", (17 * 37 + 11) & 255);
    cyc(0, 0, 1, 17, 0, "R9", 8'h5A);

    // R6 R7 R2: mixed writes and reads with random addresses and data
    for (int k = 0; k < 400; k++)
      cyc(0, $urandom_range(1), 1, $urandom_range(31), $urandom_range(255), "R6_R7_R2");

    // R5: clear after traffic
    cyc(1, 0, 0, 0, 0, "R5");
    for (int a = 0; a < 32; a++) cyc(0, 0, 1, a, 0, "R5_clear");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule